// File: doc/BRIEF.md
# Multi-Segment Programmable Twisted-Ring Pattern Generator

This block is a built-in self-test stimulus source that presents one complete test pattern to the circuit under test on every clock while it runs. The pattern vector is cut into `NSEG` equal segments of `K` bits. Each segment is its own circular shift register. Its behaviour is picked on every cycle by a two-bit field of the control word. The field can make the segment keep its value, rotate it as a plain ring, or rotate it with the wrapped bit inverted (twisted ring). Because each segment follows its own field, many more pattern sequences can be produced than with one fixed twisted-ring order.

A seed is loaded in parallel through `seed_ld`/`seed_in` to set every segment's starting state. A `start` pulse loads the run length and puts the controller into its running state. While running, each cycle in which `enable` is high and no seed load is pending presents a valid pattern (`pat_vld`). The segments then advance. Once the programmed number of valid patterns has been presented, the controller stops, raises `done` and holds the segments.

The controller has three states. GEN_IDLE is entered at reset. GEN_RUN is entered from any state on `start` with a non-zero run length. GEN_DONE is entered from GEN_RUN when the last pattern is presented, or from any state on `start` with a zero run length. Both GEN_IDLE and GEN_DONE leave only on `start`, and GEN_RUN restarts its count on `start`.

Top module: `tw_ring_patgen`

## Requirements
- R1: A synchronous active-high `rst` clears every segment to zero, puts the controller in GEN_IDLE and drives `pat_vld` and `done` low.
- R2: When `seed_ld` is high, all segments take `seed_in` at the next edge. A load wins over shifting, and a cycle with `seed_ld` high is not valid and is not counted.
- R3: Segment s (bits `[s*K +: K]` of the pattern) is controlled by `ctrl_in[2s+1:2s]`. Code 00 holds the segment, and the reserved code 11 also holds it.
- R4: Code 01 rotates the segment as a ring on each advancing cycle: the next value is `{q[K-2:0], q[K-1]}`. A segment seeded with a single one returns to its seed after exactly K advances.
- R5: Code 10 rotates the segment as a twisted ring: the next value is `{q[K-2:0], ~q[K-1]}`. A segment started from zero returns to zero after exactly 2K advances.
- R6: Segments are independent. Each follows only its own field within one cycle, whatever mix of codes the other segments use.
- R7: `pat_vld` is high exactly in GEN_RUN cycles with `enable` high and `seed_ld` low. Segments advance only on those cycles, and `pat_out` shows the segment registers directly.
- R8: In GEN_RUN with `enable` low, the segments hold and the remaining count is unchanged.
- R9: After `run_len` valid patterns the controller enters GEN_DONE. `done` stays high, `pat_vld` stays low and the segments hold until the next `start`.
- R10: `start` with `run_len` equal to zero goes straight to GEN_DONE and presents no pattern.
- R11: `start` while running reloads the count from `run_len`. The cycle of the `start` may itself present and advance a pattern, and that pattern is not counted against the new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_ld | input | 1 | Parallel seed load strobe |
| seed_in | input | NSEG*K | Seed for all segments |
| ctrl_in | input | 2*NSEG | Two-bit mode field per segment |
| run_len | input | RUN_W | Number of patterns for the next run |
| start | input | 1 | Begin a run (reload count) |
| enable | input | 1 | Allow advancing while running |
| pat_out | output | NSEG*K | Current test pattern |
| pat_vld | output | 1 | Pattern on `pat_out` is applied this cycle |
| done | output | 1 | Run finished |

## Verification
Two pairs of events can fall in one cycle. A seed load can coincide with a cycle that would otherwise shift. A `start` can coincide with the final counted pattern or with a valid shift. The bench drives `seed_ld` and `start` together at the head of every table entry, and issues `start` in the middle of a run with `enable` high. It then judges the result against its own model: the load must win and go uncounted, and the count must restart from the new `run_len` while that cycle's pattern still advances.

// File: rtl/twr_pkg.sv
package twr_pkg;
    typedef enum logic [1:0] {
        SEG_HOLD  = 2'b00,
        SEG_RING  = 2'b01,
        SEG_TWIST = 2'b10,
        SEG_RSVD  = 2'b11
    } seg_mode_e;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'b00,
        GEN_RUN  = 2'b01,
        GEN_DONE = 2'b10
    } gen_state_e;
endpackage

// File: rtl/twr_mode_switch.sv
module twr_mode_switch #(
    parameter int NSEG = 4
) (
    input  logic [2*NSEG-1:0] ctrl_in,
    output logic [NSEG-1:0]   shift_en,
    output logic [NSEG-1:0]   twist
);
    import twr_pkg::*;

    for (genvar s = 0; s < NSEG; s++) begin : g_dec
        seg_mode_e fld;
        assign fld = seg_mode_e'(ctrl_in[2*s +: 2]);
        always_comb begin
            shift_en[s] = 1'b0;
            twist[s]    = 1'b0;
            unique case (fld)
                SEG_RING:  shift_en[s] = 1'b1;
                SEG_TWIST: begin
                    shift_en[s] = 1'b1;
                    twist[s]    = 1'b1;
                end
                SEG_HOLD, SEG_RSVD: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/twr_seg_ctr.sv
module twr_seg_ctr #(
    parameter int K = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [K-1:0] seed,
    input  logic         adv,
    input  logic         shift_en,
    input  logic         twist,
    output logic [K-1:0] q
);
    logic fb;
    assign fb = q[K-1] ^ twist;

    always_ff @(posedge clk) begin
        if (rst)                 q <= '0;
        else if (ld)             q <= seed;
        else if (adv && shift_en) q <= {q[K-2:0], fb};
    end

    // R2: load wins
    assert_seed_load_R2: assert property (@(posedge clk) disable iff (rst)
        ld |=> q == $past(seed));
    // R3 / R8: no advance or hold code keeps the value
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!ld && (!shift_en || !adv)) |=> $stable(q));
    // R4: ring rotation
    assert_ring_R4: assert property (@(posedge clk) disable iff (rst)
        (!ld && adv && shift_en && !twist) |=> q == {$past(q[K-2:0]), $past(q[K-1])});
    // R5: twisted rotation
    assert_twist_R5: assert property (@(posedge clk) disable iff (rst)
        (!ld && adv && shift_en && twist) |=> q == {$past(q[K-2:0]), ~$past(q[K-1])});
endmodule

// File: rtl/twr_run_ctl.sv
module twr_run_ctl #(
    parameter int RUN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             enable,
    input  logic             hold,
    input  logic [RUN_W-1:0] run_len,
    output logic             adv,
    output logic             done
);
    import twr_pkg::*;

    gen_state_e       state, state_nx;
    logic [RUN_W-1:0] rem;
    logic             len_zero;
    logic             last;

    assign len_zero = (run_len == '0);
    assign last     = (rem == RUN_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            GEN_IDLE: if (start) state_nx = len_zero ? GEN_DONE : GEN_RUN;
            GEN_RUN: begin
                if (start)                         state_nx = len_zero ? GEN_DONE : GEN_RUN;
                else if (enable && !hold && last)  state_nx = GEN_DONE;
            end
            GEN_DONE: if (start) state_nx = len_zero ? GEN_DONE : GEN_RUN;
            default: state_nx = GEN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GEN_IDLE;
            rem   <= '0;
        end else begin
            state <= state_nx;
            if (start)    rem <= run_len;
            else if (adv) rem <= rem - RUN_W'(1);
        end
    end

    always_comb begin
        adv  = 1'b0;
        done = 1'b0;
        unique case (state)
            GEN_RUN:  adv  = enable && !hold;
            GEN_DONE: done = 1'b1;
            GEN_IDLE: ;
            default: ;
        endcase
    end

    assert_rem_live_R9: assert property (@(posedge clk) disable iff (rst)
        (state == GEN_RUN) |-> rem != '0);
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && !adv));
    assert_zero_len_R10: assert property (@(posedge clk) disable iff (rst)
        (start && len_zero) |=> done);
    assert_pause_R8: assert property (@(posedge clk) disable iff (rst)
        (state == GEN_RUN && !enable && !start) |=> $stable(rem));
    assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
        (start && !len_zero) |=> (rem == $past(run_len) && !done));
endmodule

// File: rtl/tw_ring_patgen.sv
module tw_ring_patgen #(
    parameter int NSEG  = 4,
    parameter int K     = 8,
    parameter int RUN_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                seed_ld,
    input  logic [NSEG*K-1:0]   seed_in,
    input  logic [2*NSEG-1:0]   ctrl_in,
    input  logic [RUN_W-1:0]    run_len,
    input  logic                start,
    input  logic                enable,
    output logic [NSEG*K-1:0]   pat_out,
    output logic                pat_vld,
    output logic                done
);
    localparam int W = NSEG * K;

    logic [NSEG-1:0] shift_en;
    logic [NSEG-1:0] twist;
    logic            adv;

    twr_mode_switch #(.NSEG(NSEG)) u_mode (
        .ctrl_in  (ctrl_in),
        .shift_en (shift_en),
        .twist    (twist)
    );

    twr_run_ctl #(.RUN_W(RUN_W)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .enable  (enable),
        .hold    (seed_ld),
        .run_len (run_len),
        .adv     (adv),
        .done    (done)
    );

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        twr_seg_ctr #(.K(K)) u_seg (
            .clk      (clk),
            .rst      (rst),
            .ld       (seed_ld),
            .seed     (seed_in[s*K +: K]),
            .adv      (adv),
            .shift_en (shift_en[s]),
            .twist    (twist[s]),
            .q        (pat_out[s*K +: K])
        );
    end

    assign pat_vld = adv;

    assert_vld_gate_R7: assert property (@(posedge clk) disable iff (rst)
        pat_vld |-> (enable && !seed_ld));
    assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !seed_ld && !start) |=> pat_out == $past(pat_out));
    initial assert (W > 0 && K > 1);
endmodule

// File: tb/sim_tw_ring_patgen.sv
module sim_tw_ring_patgen;
    localparam int NSEG  = 4;
    localparam int K     = 8;
    localparam int RUN_W = 16;
    localparam int W     = NSEG * K;
    localparam int NVEC  = 6;

    // entry: seed[47:16], ctrl[15:8], length[7:0]
    localparam logic [47:0] VEC [NVEC] = '{
        {32'h0000_0001, 8'h55, 8'd12},
        {32'h0F0F_3C81, 8'hAA, 8'd20},
        {32'hDEAD_BEEF, 8'hE4, 8'd10},
        {32'h8000_0001, 8'h00, 8'd5},
        {32'h1234_5678, 8'h99, 8'd17},
        {32'hFFFF_0000, 8'hFF, 8'd4}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             seed_ld = 1'b0;
    logic [W-1:0]     seed_in = '0;
    logic [2*NSEG-1:0] ctrl_in = '0;
    logic [RUN_W-1:0] run_len = '0;
    logic             start = 1'b0;
    logic             enable = 1'b0;
    logic [W-1:0]     pat_out;
    logic             pat_vld;
    logic             done;

    int n_tests = 0;
    int n_fail  = 0;

    logic [W-1:0]     m_pat = '0;
    logic             m_run = 1'b0;
    logic             m_done = 1'b0;
    logic [RUN_W-1:0] m_rem = '0;

    always #5 clk = ~clk;

    tw_ring_patgen #(.NSEG(NSEG), .K(K), .RUN_W(RUN_W)) u0 (
        .clk(clk), .rst(rst), .seed_ld(seed_ld), .seed_in(seed_in),
        .ctrl_in(ctrl_in), .run_len(run_len), .start(start), .enable(enable),
        .pat_out(pat_out), .pat_vld(pat_vld), .done(done)
    );

    function automatic logic [W-1:0] nxt(input logic [W-1:0] p, input logic [2*NSEG-1:0] c);
        logic [W-1:0] r;
        r = p;
        for (int s = 0; s < NSEG; s++) begin
            logic [K-1:0] sg;
            sg = p[s*K +: K];
            if (c[2*s +: 2] == 2'b01)      sg = {sg[K-2:0], sg[K-1]};
            else if (c[2*s +: 2] == 2'b10) sg = {sg[K-2:0], ~sg[K-1]};
            r[s*K +: K] = sg;
        end
        return r;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: inputs applied at negedge, outputs checked before posedge
    task automatic cyc(input logic ld, input logic [W-1:0] sd, input logic st, input logic en,
                       input logic [2*NSEG-1:0] ct, input logic [RUN_W-1:0] rl, input string tag);
        logic ev;
        seed_ld = ld; seed_in = sd; start = st; enable = en; ctrl_in = ct; run_len = rl;
        #1;
        ev = m_run && en && !ld;
        chk(pat_out == m_pat, {tag, " pat_out"}, 64'(pat_out), 64'(m_pat));
        chk(pat_vld == ev,    {tag, " pat_vld R7"}, 64'(pat_vld), 64'(ev));
        chk(done == m_done,   {tag, " done R9"}, 64'(done), 64'(m_done));
        if (ld)      m_pat = sd;
        else if (ev) m_pat = nxt(m_pat, ct);
        if (st) begin
            m_rem = rl; m_run = (rl != 0); m_done = (rl == 0);
        end else if (ev) begin
            if (m_rem == 1) begin m_run = 1'b0; m_done = 1'b1; end
            m_rem = m_rem - 1'b1;
        end
        @(negedge clk);
        seed_ld = 1'b0; start = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; seed_ld = 1'b0; start = 1'b0; enable = 1'b0;
        @(negedge clk); @(negedge clk);
        m_pat = '0; m_run = 1'b0; m_done = 1'b0; m_rem = '0;
        chk(pat_out == '0, "R1 pat_out zero", 64'(pat_out), 64'h0);
        chk(pat_vld == 1'b0, "R1 pat_vld low", 64'(pat_vld), 64'h0);
        chk(done == 1'b0, "R1 done low", 64'(done), 64'h0);
        rst = 1'b0;
    endtask

    task automatic period(input logic [W-1:0] sd, input logic [2*NSEG-1:0] ct, input int expect_p, input string tag);
        int first;
        first = 0;
        cyc(1'b1, sd, 1'b1, 1'b1, ct, RUN_W'(3*K), tag);
        for (int i = 1; i <= 2*K + 1; i++) begin
            cyc(1'b0, '0, 1'b0, 1'b1, ct, '0, tag);
            if (first == 0 && pat_out == sd) first = i;
        end
        chk(first == expect_p, {tag, " period"}, 64'(first), 64'(expect_p));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();                                   // R1

        // table: load+start in one cycle (R2 vs R7), then run to done (R3 R4 R5 R6 R9)
        for (int v = 0; v < NVEC; v++) begin
            logic [W-1:0] sd;
            logic [2*NSEG-1:0] ct;
            int len;
            sd = VEC[v][47:16]; ct = VEC[v][15:8]; len = int'(VEC[v][7:0]);
            cyc(1'b1, sd, 1'b1, 1'b1, ct, RUN_W'(len), "R2 load+start");
            for (int i = 0; i < len + 2; i++)
                cyc(1'b0, '0, 1'b0, 1'b1, ct, '0, "R6 table run");
        end

        // R4 ring period K, R5 twisted period 2K from zero
        period(32'h0000_0001, 8'h55, K, "R4");
        period(32'h0000_0000, 8'hAA, 2*K, "R5");

        // R3 reserved code holds: observe pattern unchanged during run
        cyc(1'b1, 32'hA5C3_0F96, 1'b1, 1'b1, 8'hFF, 16'd6, "R3 reserved");
        for (int i = 0; i < 4; i++) cyc(1'b0, '0, 1'b0, 1'b1, 8'hFF, '0, "R3 reserved hold");
        chk(pat_out == 32'hA5C3_0F96, "R3 reserved unchanged", 64'(pat_out), 64'hA5C3_0F96);

        // R8 pause, then R2 load mid-run (load wins, not counted)
        cyc(1'b1, 32'h0102_0408, 1'b1, 1'b1, 8'h55, 16'd6, "R8 begin");
        cyc(1'b0, '0, 1'b0, 1'b1, 8'h55, '0, "R8 step");
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b0, 1'b0, 8'h55, '0, "R8 paused");
        cyc(1'b1, 32'h7777_1111, 1'b0, 1'b1, 8'h55, '0, "R2 load mid-run");
        for (int i = 0; i < 7; i++) cyc(1'b0, '0, 1'b0, 1'b1, 8'hA6, '0, "R8 resume");
        chk(done == 1'b1, "R8 done after exact count", 64'(done), 64'h1);

        // R11 restart during run
        cyc(1'b0, '0, 1'b1, 1'b1, 8'h5A, 16'd8, "R11 first start");
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b0, 1'b1, 8'h5A, '0, "R11 run");
        cyc(1'b0, '0, 1'b1, 1'b1, 8'h5A, 16'd4, "R11 restart");
        for (int i = 0; i < 6; i++) cyc(1'b0, '0, 1'b0, 1'b1, 8'h5A, '0, "R11 after");

        // R10 zero length
        cyc(1'b0, '0, 1'b1, 1'b1, 8'h55, 16'd0, "R10 zero start");
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b0, 1'b1, 8'h55, '0, "R10 idle");
        chk(done == 1'b1 && pat_vld == 1'b0, "R10 done no pattern", 64'({done, pat_vld}), 64'h2);

        // R1 reset in the middle of a run
        cyc(1'b1, 32'hCAFE_F00D, 1'b1, 1'b1, 8'hAA, 16'd9, "R1 pre-reset");
        cyc(1'b0, '0, 1'b0, 1'b1, 8'hAA, '0, "R1 pre-reset run");
        do_reset();
        cyc(1'b0, '0, 1'b0, 1'b1, 8'hAA, '0, "R1 idle after reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule